// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Controller

This block collects every interrupt and reset request of a small processor and chooses which one the CPU serves next. It outputs the 16-bit word address of the matching vector slot, together with a valid strobe. The requests fall into three classes, and each class has its own masking rule. Reset-class requests cannot be masked. Non-maskable requests obey only their own enable bits. Maskable requests need their own enable bit and the global enable. The highest class always wins. Inside the maskable class, the higher line index wins.

Once a vector is presented, it stays on the outputs until the CPU acknowledges it. Clearing the source flags is the job of the source modules. The block supplies two reset-class events of its own:
- **Power-up request.** It is pending when reset is released and is cleared when the reset vector is acknowledged.
- **Fetch fault.** It is latched when the CPU fetches an instruction from the peripheral register window or from an unused address hole.

During power-up the CPU reads the reset vector word and reports it to the block. If that word reads as erased (all ones), the block raises a sticky request to enter the deepest low-power mode. While that request is high, no vector is ever presented.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst_n` is low, `irq_valid` and `lpm_req` are 0 and `irq_vector` is 0x0000.
- R2: After reset is released, a power-up request is pending. On the first clock edge `irq_valid` rises with `irq_vector` = 0xFFFE. Acknowledging that vector clears the power-up request.
- R3: Any bit of `rst_req` and a latched fetch fault select vector 0xFFFE. This vector beats every other pending request.
- R4: Non-maskable line k is pending when `nmi_flag[k]` and `nmi_en[k]` are both 1. It selects 0xFFFC whatever the value of `gie`. A cleared `nmi_en` bit blocks its line.
- R5: Maskable line i is pending only when `mask_flag[i]`, `mask_en[i]` and `gie` are all 1. It selects vector 0xFFDC + 2*i, so line 15 gives 0xFFFA. When several lines are pending, the highest index wins.
- R6: Class precedence is reset, then non-maskable, then maskable. The choice is taken from the requests pending in the cycle the vector is registered.
- R7: While `irq_valid` is 1 and `ack` is 0, `irq_valid` stays 1 and `irq_vector` is unchanged, even if new requests arrive. `ack` with `irq_valid` high drops `irq_valid` on the next edge. Selection then resumes one cycle later.
- R8: `ack` while `irq_valid` is 0 has no effect.
- R9: A cycle with `fetch_valid` = 1 and `fetch_addr` in the fault ranges latches a fetch fault. The fault ranges are 0x0000–0x01FF and 0x2000–0x2FFF. The fault stays until a 0xFFFE vector is acknowledged. Fetches from other addresses have no effect.
- R10: Suppose `rstvec_valid` is 1 while the power-up request is pending and `rstvec_data` = 0xFFFF. Then `lpm_req` goes to 1 on the next edge and stays 1 until reset. While it is 1, `irq_valid` is 0. Any other reset vector value has no effect.
- R11: A presented vector is always even and lies in 0xFFDC–0xFFFE. Slots 0xFFC0–0xFFDA are never selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gie | input | 1 | Global enable for the maskable class |
| rst_req | input | 4 | Reset-class requests (external pin, watchdog, key violation, spare) |
| nmi_flag | input | 3 | Non-maskable request flags |
| nmi_en | input | 3 | Per-line enables for the non-maskable flags |
| mask_flag | input | 16 | Maskable request flags, one per vector slot |
| mask_en | input | 16 | Per-line enables for the maskable flags |
| fetch_valid | input | 1 | CPU instruction fetch in this cycle |
| fetch_addr | input | 16 | Address of that fetch |
| rstvec_valid | input | 1 | Power-up read of the reset vector word is on `rstvec_data` |
| rstvec_data | input | 16 | Reset vector word as read |
| ack | input | 1 | CPU accepts the presented vector |
| irq_valid | output | 1 | A vector is presented |
| irq_vector | output | 16 | Word address of the presented vector |
| lpm_req | output | 1 | Request to enter the deepest low-power mode |

## Verification
A power-up or fetch-fault flag that is stuck or cleared too early shows up directly at the ports. After an acknowledge, such a flag makes 0xFFFE reappear, or fail to appear, within two cycles. A wrong lock of the presented vector shows as `irq_vector` changing while `irq_valid` is held, visible on the very next edge. Masking errors show as a vector appearing, or missing, one edge after the request pattern changes. The bench compares every output against a behavioural model on every cycle, so each of these faults is reported in the cycle it first shows.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int          N_RST   = 4,
  parameter int          N_NMI   = 3,
  parameter int          N_MASK  = 16,
  parameter logic [15:0] REG_TOP = 16'h01FF,
  parameter logic [15:0] HOLE_LO = 16'h2000,
  parameter logic [15:0] HOLE_HI = 16'h2FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gie,
  input  logic [N_RST-1:0]  rst_req,
  input  logic [N_NMI-1:0]  nmi_flag,
  input  logic [N_NMI-1:0]  nmi_en,
  input  logic [N_MASK-1:0] mask_flag,
  input  logic [N_MASK-1:0] mask_en,
  input  logic              fetch_valid,
  input  logic [15:0]       fetch_addr,
  input  logic              rstvec_valid,
  input  logic [15:0]       rstvec_data,
  input  logic              ack,
  output logic              irq_valid,
  output logic [15:0]       irq_vector,
  output logic              lpm_req
);
  localparam logic [15:0] VEC_RST  = 16'hFFFE;
  localparam logic [15:0] VEC_NMI  = 16'hFFFC;
  localparam logic [15:0] VEC_LOW  = 16'(16'hFFFA - 2 * (N_MASK - 1));
  localparam logic [15:0] ERASED   = 16'hFFFF;

  logic pu_pend, pc_fault;
  logic [N_MASK-1:0] mask_hit;
  logic [15:0] mask_vec, sel_vec;

  wire fetch_bad = fetch_valid &&
                   (fetch_addr <= REG_TOP || (fetch_addr >= HOLE_LO && fetch_addr <= HOLE_HI));
  wire lpm_hit   = rstvec_valid && pu_pend && rstvec_data == ERASED;
  wire rst_any   = pu_pend || pc_fault || |rst_req;
  wire nmi_any   = |(nmi_flag & nmi_en);
  assign mask_hit = mask_flag & mask_en & {N_MASK{gie}};
  wire mask_any  = |mask_hit;
  wire any_pend  = rst_any || nmi_any || mask_any;

  always_comb begin
    mask_vec = VEC_LOW;
    for (int i = 0; i < N_MASK; i++)
      if (mask_hit[i]) mask_vec = VEC_LOW + 16'(2 * i);
  end

  assign sel_vec = rst_any ? VEC_RST : nmi_any ? VEC_NMI : mask_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= 16'h0000;
      lpm_req    <= 1'b0;
      pu_pend    <= 1'b1;
      pc_fault   <= 1'b0;
    end else begin
      if (lpm_hit) lpm_req <= 1'b1;
      if (lpm_req || lpm_hit) begin
        irq_valid <= 1'b0;
      end else if (irq_valid) begin
        if (ack) begin
          irq_valid <= 1'b0;
          if (irq_vector == VEC_RST) begin
            pu_pend  <= 1'b0;
            pc_fault <= 1'b0;
          end
        end
      end else if (any_pend) begin
        irq_valid  <= 1'b1;
        irq_vector <= sel_vec;
      end
      if (fetch_bad) pc_fault <= 1'b1;
    end
  end

  assert_vec_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector >= VEC_LOW && !irq_vector[0]));

  assert_hold_until_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !ack && !lpm_hit) |=> (irq_valid && $stable(irq_vector)));

  assert_ack_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && ack) |=> !irq_valid);

  assert_nmi_ignores_gie_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_valid && !lpm_req && !lpm_hit && !rst_any && nmi_any) |=> (irq_valid && irq_vector == VEC_NMI));

  assert_gie_blocks_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie && !rst_any && !nmi_any && !irq_valid) |=> !irq_valid);

  assert_lpm_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lpm_req |=> (lpm_req && !irq_valid));
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, gie = 1'b0;
  logic [3:0]  rst_req = '0;
  logic [2:0]  nmi_flag = '0, nmi_en = '0;
  logic [15:0] mask_flag = '0, mask_en = '0;
  logic fetch_valid = 1'b0, rstvec_valid = 1'b0, ack = 1'b0;
  logic [15:0] fetch_addr = '0, rstvec_data = '0;
  logic irq_valid, lpm_req;
  logic [15:0] irq_vector;

  irq_vector_ctrl dut (.clk, .rst_n, .gie, .rst_req, .nmi_flag, .nmi_en, .mask_flag,
    .mask_en, .fetch_valid, .fetch_addr, .rstvec_valid, .rstvec_data, .ack,
    .irq_valid, .irq_vector, .lpm_req);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  string tag = "R1";
  bit m_valid, m_lpm, m_pu, m_fault;
  int m_vec;

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
    end
  end

  task automatic check(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic model_reset();
    m_valid = 0; m_lpm = 0; m_pu = 1; m_fault = 0; m_vec = 0;
  endtask

  task automatic step();
    bit bad, lhit;
    int best;
    bad = fetch_valid && (fetch_addr < 16'h0200 || (fetch_addr >= 16'h2000 && fetch_addr < 16'h3000));
    lhit = rstvec_valid && m_pu && rstvec_data == 16'hFFFF;
    best = -1;
    if (m_pu || m_fault || rst_req != 0) best = 31;
    else if ((nmi_flag & nmi_en) != 0) best = 30;
    else if (gie) for (int i = 0; i < 16; i++) if (mask_flag[i] && mask_en[i]) best = 14 + i;
    if (lhit) m_lpm = 1;
    if (m_lpm) m_valid = 0;
    else if (m_valid) begin
      if (ack) begin
        m_valid = 0;
        if (m_vec == 16'hFFFE) begin m_pu = 0; m_fault = 0; end
      end
    end else if (best >= 0) begin
      m_valid = 1; m_vec = 16'hFFC0 + 2 * best;
    end
    if (bad) m_fault = 1;
    @(posedge clk); @(negedge clk);
    check({tag, " valid"}, int'(irq_valid), int'(m_valid));
    check({tag, " vector"}, int'(irq_vector), m_vec);
    check({tag, " lpm"}, int'(lpm_req), int'(m_lpm));
  endtask

  task automatic do_reset();
    rst_n = 0; model_reset();
    @(negedge clk);
    tag = "R1";
    check("R1 valid in reset", int'(irq_valid), 0);
    check("R1 vector in reset", int'(irq_vector), 0);
    check("R1 lpm in reset", int'(lpm_req), 0);
    rst_n = 1;
  endtask

  initial begin
    do_reset();
    tag = "R10"; rstvec_valid = 1; rstvec_data = 16'h1234; step(); rstvec_valid = 0;
    tag = "R2";
    check("R2 power-up vector", int'(irq_vector), 16'hFFFE);
    step(); ack = 1; step(); ack = 0; step(); step();
    check("R2 power-up cleared", int'(irq_valid), 0);

    tag = "R5"; gie = 1; mask_flag[3] = 1; mask_en[3] = 1; step();
    check("R5 line 3 vector", int'(irq_vector), 16'hFFE2);
    tag = "R7"; mask_flag[10] = 1; mask_en[10] = 1; step(); step();
    check("R7 vector held", int'(irq_vector), 16'hFFE2);
    ack = 1; step(); ack = 0; step();
    tag = "R5"; check("R5 highest line wins", int'(irq_vector), 16'hFFF0);
    ack = 1; step(); ack = 0; mask_flag = '0; step();
    mask_flag[15] = 1; mask_en[15] = 1; step();
    check("R5 line 15 at FFFA", int'(irq_vector), 16'hFFFA);
    ack = 1; step(); ack = 0; gie = 0; step(); step();
    check("R5 gie blocks", int'(irq_valid), 0);
    gie = 1; mask_en = '0; step(); step();
    check("R5 enable blocks", int'(irq_valid), 0);

    tag = "R4"; gie = 0; nmi_flag = 3'b010; nmi_en = 3'b010; step();
    check("R4 nmi without gie", int'(irq_vector), 16'hFFFC);
    ack = 1; step(); ack = 0; nmi_en = 3'b101; step(); step();
    check("R4 nmi enable blocks", int'(irq_valid), 0);

    tag = "R6"; gie = 1; mask_en = 16'hFFFF; mask_flag = 16'h0001; nmi_en = 3'b111;
    rst_req = 4'b0100; step();
    check("R6 R3 reset wins", int'(irq_vector), 16'hFFFE);
    ack = 1; step(); ack = 0; rst_req = 0; step();
    check("R6 nmi next", int'(irq_vector), 16'hFFFC);
    ack = 1; step(); ack = 0; nmi_flag = 0; step();
    check("R6 maskable last", int'(irq_vector), 16'hFFDC);
    ack = 1; step(); ack = 0; mask_flag = 0; step();

    tag = "R8"; ack = 1; step(); step(); ack = 0; step();
    check("R8 idle ack no effect", int'(irq_valid), 0);
    mask_flag[2] = 1; step();
    check("R8 later request served", int'(irq_vector), 16'hFFE0);
    ack = 1; step(); ack = 0; mask_flag = 0; step();

    tag = "R9"; fetch_valid = 1; fetch_addr = 16'h4000; step();
    fetch_addr = 16'h0200; step(); fetch_addr = 16'h1FFF; step(); fetch_addr = 16'h3000; step();
    fetch_valid = 0; step();
    check("R9 legal fetch ignored", int'(irq_valid), 0);
    fetch_valid = 1; fetch_addr = 16'h01FF; step(); fetch_valid = 0; step();
    check("R9 register window fault", int'(irq_vector), 16'hFFFE);
    ack = 1; step(); ack = 0; step(); step();
    check("R9 fault cleared by ack", int'(irq_valid), 0);
    fetch_valid = 1; fetch_addr = 16'h2ABC; step(); fetch_valid = 0; step();
    check("R9 hole fault", int'(irq_vector), 16'hFFFE);
    step(); ack = 1; step(); ack = 0; step();

    do_reset();
    tag = "R10"; rstvec_valid = 1; rstvec_data = 16'hFFFF; step(); rstvec_valid = 0;
    check("R10 erased vector lpm", int'(lpm_req), 1);
    check("R10 nothing presented", int'(irq_valid), 0);
    rst_req = 4'b0001; nmi_flag = 3'b001; mask_flag = 16'h0100; step(); step(); step();
    check("R10 lpm sticky", int'(lpm_req), 1);
    rst_req = 0; nmi_flag = 0; mask_flag = 0;

    do_reset();
    tag = "R11"; step();
    check("R11 R2 vector after second reset", int'(irq_vector), 16'hFFFE);
    ack = 1; step(); ack = 0; step();
    for (int i = 0; i < 16; i++) begin
      mask_flag = 16'(1) << i; step();
      check("R11 slot address", int'(irq_vector), 16'hFFDC + 2 * i);
      ack = 1; step(); ack = 0; mask_flag = 0; step();
    end
    done = 1;
    summary();
  end
endmodule